// File: doc/BRIEF.md
# SDRAM Command Sequencer

This block connects a single-word host request port to a four-bank single-data-rate SDRAM. The SDRAM has 12 row bits, 8 column bits and a 16-bit data bus. After reset it waits for the power-up interval. It then precharges every bank, issues two auto-refresh commands and programs the mode register, after which it starts serving the host. A host request names a bank, row and column. It says whether the access is a read or a write, and whether the bank should close itself once the access is done. The block keeps the open row of each bank. A request that hits the open row goes straight to the column command. A request that misses first closes the bank and then opens the new row. Every minimum spacing between commands is a parameter counted in whole clock cycles.

A refresh timer raises a refresh request at a fixed interval. Refresh takes priority over host traffic: open banks are closed with a precharge-all, and the refresh command follows once every bank has recovered. Burst length is one word. Read data capture and burst column stepping belong to a separate datapath block, so the command and write-data pins are the only interface toward the memory.

The host side is valid/ready. The host raises `req_valid` and holds address, direction, auto-close flag and write data steady until it sees `req_ready`. `req_ready` is asserted only in the cycle when the read or write command for that request is chosen. The controller applies back-pressure for as long as it needs to precharge, activate, wait out a timing window or run a refresh.

Top module: `sdram_cmd_ctrl`

## Requirements
- R1: The command pins {cs_n,ras_n,cas_n,we_n} carry only these codes: 0000 mode-register set, 0001 auto-refresh, 0010 precharge, 0011 activate, 0100 write, 0101 read, 0111 no-op. Each command is the next one the host traffic calls for, and nothing else is issued.
- R2: During reset the pins show no-op, with `sd_dq_oe` and `req_ready` low. After reset at least INIT_CYC no-op cycles pass. The block then issues, in order: a precharge with A10=1, two auto-refreshes, and a mode-register set whose address equals MODE_WORD.
- R3: After a mode-register set, the next command comes no sooner than T_MRD cycles later.
- R4: Mode-register set and auto-refresh are issued only while every bank is closed.
- R5: An activate carries the bank on `sd_ba` and the row on `sd_addr`. A read or write carries the bank on `sd_ba` and the column on `sd_addr[7:0]`, and is issued only to an open bank. A write drives `req_wdata` on `sd_dq_out` with `sd_dq_oe` high in the same cycle, and `sd_dq_oe` is low with every other command.
- R6: In each bank, a read or write comes at least T_RCD cycles after the activate, a precharge at least T_RAS cycles after it, and the next activate at least T_RC cycles after it. Activates to any two banks are at least T_RRD cycles apart.
- R7: A precharge to a bank comes at least T_WR cycles after a write to that bank. An activate comes at least T_RP cycles after a precharge of that bank.
- R8: A request to the open row of its bank issues no activate. A request to another row of an open bank issues a precharge to that bank (A10=0), then an activate, then the column command. An activate is never issued to an open bank.
- R9: A read or write with `req_autopre` high drives A10=1 and is issued no sooner than T_RAS cycles after the bank's activate. The bank is closed afterwards. Its next activate comes at least T_RP cycles after an auto-closing read, and at least T_WR+T_RP cycles after an auto-closing write.
- R10: A precharge with A10=1 closes all banks whatever `sd_ba` holds, so the next access to any bank starts with an activate.
- R11: A refresh request arises every REFI_CYC cycles once the block is running. It is served before host requests: a precharge-all is issued first if any bank is open, then an auto-refresh. Consecutive refreshes on an idle bus lie REFI_CYC cycles apart within a small tolerance. No command follows a refresh for T_RFC cycles.
- R12: `req_ready` is high only in the cycle when the request's read or write is chosen. That command appears on the pins in the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Host request present |
| req_ready | output | 1 | Request accepted this cycle |
| req_write | input | 1 | 1 = write, 0 = read |
| req_autopre | input | 1 | Close the bank after this access |
| req_addr | input | 22 | {bank[1:0], row[11:0], column[7:0]} |
| req_wdata | input | 16 | Write data |
| sd_cs_n | output | 1 | Chip select, active low |
| sd_ras_n | output | 1 | Row strobe, active low |
| sd_cas_n | output | 1 | Column strobe, active low |
| sd_we_n | output | 1 | Write enable, active low |
| sd_ba | output | 2 | Bank select |
| sd_addr | output | 12 | Multiplexed row/column address, A10 = auto-close / all-bank flag |
| sd_dq_out | output | 16 | Write data toward the data pins |
| sd_dq_oe | output | 1 | Drive enable for the data pins |

## Verification
The first access is a write to a closed bank, which shows the activate and the activate-to-column wait. A read to the same row follows, and it must go out without an activate. A read to another row of that bank must produce a precharge, an activate and a read, which tells a hit from a miss and exercises write recovery. An auto-closing write followed by a read to the same row shows that the bank was closed, and it checks the longer reopen delay. Reads to two further banks exercise the cross-bank activate spacing. The run then waits for two refreshes: the first must start with a precharge-all because banks are open, and the second must not, which separates the two refresh paths and measures the interval. A final read to a formerly open row confirms that the all-bank precharge closed it.

// File: rtl/sdram_ctrl_pkg.sv
package sdram_ctrl_pkg;

  // {cs_n, ras_n, cas_n, we_n}
  typedef enum logic [3:0] {
    CMD_MRS = 4'b0000,
    CMD_REF = 4'b0001,
    CMD_PRE = 4'b0010,
    CMD_ACT = 4'b0011,
    CMD_WR  = 4'b0100,
    CMD_RD  = 4'b0101,
    CMD_BST = 4'b0110,
    CMD_NOP = 4'b0111
  } sd_cmd_e;

  typedef enum logic [2:0] {
    ST_POWER,
    ST_INIT_PRE,
    ST_INIT_REF,
    ST_INIT_MRS,
    ST_RUN
  } ctl_state_e;

endpackage

// File: rtl/sdram_bank_state.sv
// One bank: open flag, open row and the timing windows that gate its commands.
module sdram_bank_state #(
  parameter int ROW_W = 12,
  parameter int CNT_W = 8,
  parameter int T_RCD = 3,
  parameter int T_RAS = 6,
  parameter int T_RC  = 9,
  parameter int T_RP  = 3,
  parameter int T_WR  = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             act_i,
  input  logic             rw_i,
  input  logic             wr_i,
  input  logic             ap_i,
  input  logic             pre_i,
  input  logic [ROW_W-1:0] row_i,
  output logic             is_open_o,
  output logic [ROW_W-1:0] row_o,
  output logic             rw_ok_o,
  output logic             pre_ok_o,
  output logic             act_ok_o
);
  localparam logic [CNT_W-1:0] L_RCD = CNT_W'(T_RCD - 1);
  localparam logic [CNT_W-1:0] L_RAS = CNT_W'(T_RAS - 1);
  localparam logic [CNT_W-1:0] L_RC  = CNT_W'(T_RC - 1);
  localparam logic [CNT_W-1:0] L_RP  = CNT_W'(T_RP - 1);
  localparam logic [CNT_W-1:0] L_WR  = CNT_W'(T_WR - 1);
  localparam logic [CNT_W-1:0] L_APW = CNT_W'(T_RP + T_WR - 1);

  logic             open_q;
  logic [ROW_W-1:0] row_q;
  logic [CNT_W-1:0] rcd_q, ras_q, rc_q, rp_q, wr_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      open_q <= 1'b0;
      row_q  <= '0;
      rcd_q  <= '0;
      ras_q  <= '0;
      rc_q   <= '0;
      rp_q   <= '0;
      wr_q   <= '0;
    end else begin
      if (rcd_q != '0) rcd_q <= rcd_q - 1'b1;
      if (ras_q != '0) ras_q <= ras_q - 1'b1;
      if (rc_q  != '0) rc_q  <= rc_q  - 1'b1;
      if (rp_q  != '0) rp_q  <= rp_q  - 1'b1;
      if (wr_q  != '0) wr_q  <= wr_q  - 1'b1;
      if (act_i) begin
        open_q <= 1'b1;
        row_q  <= row_i;
        rcd_q  <= L_RCD;
        ras_q  <= L_RAS;
        rc_q   <= L_RC;
      end
      if (rw_i && wr_i) wr_q <= L_WR;
      if (rw_i && ap_i) begin
        open_q <= 1'b0;
        rp_q   <= wr_i ? L_APW : L_RP;
      end
      if (pre_i) begin
        open_q <= 1'b0;
        rp_q   <= L_RP;
      end
    end
  end

  assign is_open_o = open_q;
  assign row_o     = row_q;
  assign rw_ok_o   = open_q && (rcd_q == '0);
  assign pre_ok_o  = open_q && (ras_q == '0) && (wr_q == '0);
  assign act_ok_o  = !open_q && (rp_q == '0) && (rc_q == '0);
endmodule

// File: rtl/sdram_refresh_timer.sv
// Raises a sticky refresh request every REFI_CYC cycles while running.
module sdram_refresh_timer #(
  parameter int REFI_CYC = 780
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run_i,
  input  logic ref_done_i,
  output logic pend_o
);
  localparam int TW = $clog2(REFI_CYC + 1);

  logic [TW-1:0] cnt_q;
  logic          wrap;

  assign wrap = run_i && (cnt_q == TW'(REFI_CYC - 1));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt_q  <= '0;
      pend_o <= 1'b0;
    end else begin
      if (!run_i || wrap) cnt_q <= '0;
      else                cnt_q <= cnt_q + 1'b1;
      if (wrap)            pend_o <= 1'b1;
      else if (ref_done_i) pend_o <= 1'b0;
    end
  end
endmodule

// File: rtl/sdram_cmd_ctrl.sv
module sdram_cmd_ctrl
  import sdram_ctrl_pkg::*;
#(
  parameter int          BA_W      = 2,
  parameter int          ROW_W     = 12,
  parameter int          COL_W     = 8,
  parameter int          DQ_W      = 16,
  parameter int          CNT_W     = 8,
  parameter int          T_RCD     = 3,
  parameter int          T_RP      = 3,
  parameter int          T_RAS     = 6,
  parameter int          T_RC      = 9,
  parameter int          T_RRD     = 2,
  parameter int          T_WR      = 2,
  parameter int          T_MRD     = 2,
  parameter int          T_RFC     = 7,
  parameter int          INIT_CYC  = 10000,
  parameter int          REFI_CYC  = 780,
  parameter logic [11:0] MODE_WORD = 12'h020
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          req_valid,
  output logic                          req_ready,
  input  logic                          req_write,
  input  logic                          req_autopre,
  input  logic [BA_W+ROW_W+COL_W-1:0]   req_addr,
  input  logic [DQ_W-1:0]               req_wdata,
  output logic                          sd_cs_n,
  output logic                          sd_ras_n,
  output logic                          sd_cas_n,
  output logic                          sd_we_n,
  output logic [BA_W-1:0]               sd_ba,
  output logic [ROW_W-1:0]              sd_addr,
  output logic [DQ_W-1:0]               sd_dq_out,
  output logic                          sd_dq_oe
);
  localparam int NBANK  = 1 << BA_W;
  localparam int AW     = BA_W + ROW_W + COL_W;
  localparam int INIT_W = $clog2(INIT_CYC + 1);
  localparam logic [CNT_W-1:0] L_MRD = CNT_W'(T_MRD - 1);
  localparam logic [CNT_W-1:0] L_RFC = CNT_W'(T_RFC - 1);
  localparam logic [CNT_W-1:0] L_RP  = CNT_W'(T_RP - 1);
  localparam logic [CNT_W-1:0] L_RRD = CNT_W'(T_RRD - 1);

  ctl_state_e       st_q, st_d;
  logic [INIT_W-1:0] init_q;
  logic             ref_cnt_q, ref_cnt_d;
  logic [CNT_W-1:0] gap_q, gap_d, rrd_q, rrd_d;
  sd_cmd_e          cmd_q, cmd_d;
  logic [BA_W-1:0]  ba_q, ba_d;
  logic [ROW_W-1:0] addr_q, addr_d;
  logic [DQ_W-1:0]  dq_q, dq_d;
  logic             oe_q, oe_d;

  logic [NBANK-1:0] act_v, rw_v, pre_v, is_open, rw_ok, pre_ok, act_ok;
  logic [ROW_W-1:0] open_row [NBANK];
  logic             pre_all, ref_fire, ref_pend;

  logic [BA_W-1:0]  req_ba;
  logic [ROW_W-1:0] req_row;
  logic [COL_W-1:0] req_col;
  assign req_ba  = req_addr[AW-1 -: BA_W];
  assign req_row = req_addr[COL_W +: ROW_W];
  assign req_col = req_addr[COL_W-1:0];

  logic any_open, close_all_ok;
  assign any_open     = |is_open;
  assign close_all_ok = &(pre_ok | ~is_open);

  for (genvar g = 0; g < NBANK; g++) begin : g_bank
    sdram_bank_state #(
      .ROW_W(ROW_W), .CNT_W(CNT_W), .T_RCD(T_RCD), .T_RAS(T_RAS),
      .T_RC(T_RC), .T_RP(T_RP), .T_WR(T_WR)
    ) u_bank (
      .clk(clk), .rst_n(rst_n),
      .act_i(act_v[g]), .rw_i(rw_v[g]), .wr_i(req_write), .ap_i(req_autopre),
      .pre_i(pre_v[g] | pre_all), .row_i(req_row),
      .is_open_o(is_open[g]), .row_o(open_row[g]),
      .rw_ok_o(rw_ok[g]), .pre_ok_o(pre_ok[g]), .act_ok_o(act_ok[g])
    );
  end

  sdram_refresh_timer #(.REFI_CYC(REFI_CYC)) u_refi (
    .clk(clk), .rst_n(rst_n), .run_i(st_q == ST_RUN),
    .ref_done_i(ref_fire), .pend_o(ref_pend)
  );

  always_comb begin
    st_d      = st_q;
    ref_cnt_d = ref_cnt_q;
    gap_d     = (gap_q != '0) ? gap_q - 1'b1 : '0;
    rrd_d     = (rrd_q != '0) ? rrd_q - 1'b1 : '0;
    cmd_d     = CMD_NOP;
    ba_d      = '0;
    addr_d    = '0;
    dq_d      = '0;
    oe_d      = 1'b0;
    act_v     = '0;
    rw_v      = '0;
    pre_v     = '0;
    pre_all   = 1'b0;
    ref_fire  = 1'b0;
    req_ready = 1'b0;
    case (st_q)
      ST_POWER: if (init_q == INIT_W'(INIT_CYC - 1)) st_d = ST_INIT_PRE;
      ST_INIT_PRE: if (gap_q == '0) begin
        cmd_d      = CMD_PRE;
        addr_d[10] = 1'b1;
        pre_all    = 1'b1;
        gap_d      = L_RP;
        ref_cnt_d  = 1'b0;
        st_d       = ST_INIT_REF;
      end
      ST_INIT_REF: if (gap_q == '0 && &act_ok) begin
        cmd_d     = CMD_REF;
        gap_d     = L_RFC;
        ref_cnt_d = 1'b1;
        if (ref_cnt_q) st_d = ST_INIT_MRS;
      end
      ST_INIT_MRS: if (gap_q == '0) begin
        cmd_d  = CMD_MRS;
        addr_d = ROW_W'(MODE_WORD);
        gap_d  = L_MRD;
        st_d   = ST_RUN;
      end
      ST_RUN: if (gap_q == '0) begin
        if (ref_pend) begin
          if (any_open) begin
            if (close_all_ok) begin
              cmd_d      = CMD_PRE;
              addr_d[10] = 1'b1;
              pre_all    = 1'b1;
              gap_d      = L_RP;
            end
          end else if (&act_ok) begin
            cmd_d    = CMD_REF;
            gap_d    = L_RFC;
            ref_fire = 1'b1;
          end
        end else if (req_valid) begin
          ba_d = req_ba;
          if (is_open[req_ba]) begin
            if (open_row[req_ba] == req_row) begin
              if (rw_ok[req_ba] && (!req_autopre || pre_ok[req_ba])) begin
                cmd_d          = req_write ? CMD_WR : CMD_RD;
                addr_d         = ROW_W'(req_col);
                addr_d[10]     = req_autopre;
                dq_d           = req_wdata;
                oe_d           = req_write;
                rw_v[req_ba]   = 1'b1;
                req_ready      = 1'b1;
              end
            end else if (pre_ok[req_ba]) begin
              cmd_d         = CMD_PRE;
              pre_v[req_ba] = 1'b1;
            end
          end else if (act_ok[req_ba] && rrd_q == '0) begin
            cmd_d         = CMD_ACT;
            addr_d        = req_row;
            act_v[req_ba] = 1'b1;
            rrd_d         = L_RRD;
          end
        end
      end
      default: st_d = ST_POWER;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st_q      <= ST_POWER;
      init_q    <= '0;
      ref_cnt_q <= 1'b0;
      gap_q     <= '0;
      rrd_q     <= '0;
      cmd_q     <= CMD_NOP;
      ba_q      <= '0;
      addr_q    <= '0;
      dq_q      <= '0;
      oe_q      <= 1'b0;
    end else begin
      st_q      <= st_d;
      if (st_q == ST_POWER) init_q <= init_q + 1'b1;
      ref_cnt_q <= ref_cnt_d;
      gap_q     <= gap_d;
      rrd_q     <= rrd_d;
      cmd_q     <= cmd_d;
      ba_q      <= ba_d;
      addr_q    <= addr_d;
      dq_q      <= dq_d;
      oe_q      <= oe_d;
    end
  end

  assign {sd_cs_n, sd_ras_n, sd_cas_n, sd_we_n} = cmd_q;
  assign sd_ba     = ba_q;
  assign sd_addr   = addr_q;
  assign sd_dq_out = dq_q;
  assign sd_dq_oe  = oe_q;
endmodule

// File: rtl/sdram_cmd_ctrl_chk.sv
// Pin-level protocol checker; keeps its own bank-open shadow from the command pins.
module sdram_cmd_ctrl_chk
  import sdram_ctrl_pkg::*;
#(
  parameter int BA_W  = 2,
  parameter int ROW_W = 12
) (
  input logic             clk,
  input logic             rst_n,
  input logic             req_valid,
  input logic             req_ready,
  input logic             sd_cs_n,
  input logic             sd_ras_n,
  input logic             sd_cas_n,
  input logic             sd_we_n,
  input logic [BA_W-1:0]  sd_ba,
  input logic [ROW_W-1:0] sd_addr
);
  localparam int NBANK = 1 << BA_W;

  logic [3:0]       cmd;
  logic [NBANK-1:0] open_q;
  assign cmd = {sd_cs_n, sd_ras_n, sd_cas_n, sd_we_n};

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      open_q <= '0;
    end else begin
      if (cmd == CMD_ACT) open_q[sd_ba] <= 1'b1;
      if ((cmd == CMD_RD || cmd == CMD_WR) && sd_addr[10]) open_q[sd_ba] <= 1'b0;
      if (cmd == CMD_PRE) begin
        if (sd_addr[10]) open_q <= '0;
        else             open_q[sd_ba] <= 1'b0;
      end
    end
  end

  p_mrs_ref_idle_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd == CMD_MRS || cmd == CMD_REF) |-> (open_q == '0));

  p_mrs_gap_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd == CMD_MRS) |=> (cmd == CMD_NOP));

  p_act_closed_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd == CMD_ACT) |-> !open_q[sd_ba]);

  p_rw_open_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd == CMD_RD || cmd == CMD_WR) |-> open_q[sd_ba]);

  p_ready_cmd_r12: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready) |=> (cmd == CMD_RD || cmd == CMD_WR));
endmodule

bind sdram_cmd_ctrl sdram_cmd_ctrl_chk #(.BA_W(BA_W), .ROW_W(ROW_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
  .sd_cs_n(sd_cs_n), .sd_ras_n(sd_ras_n), .sd_cas_n(sd_cas_n), .sd_we_n(sd_we_n),
  .sd_ba(sd_ba), .sd_addr(sd_addr)
);

// File: tb/sdram_cmd_ctrl_tb.sv
module sdram_cmd_ctrl_tb;
  localparam int T_RCD = 3, T_RP = 3, T_RAS = 6, T_RC = 9, T_RRD = 2;
  localparam int T_WR = 2, T_MRD = 2, T_RFC = 7, INIT_CYC = 20, REFI_CYC = 2000;
  localparam logic [11:0] MODE = 12'h020;
  localparam logic [3:0] C_MRS = 4'b0000, C_REF = 4'b0001, C_PRE = 4'b0010,
                         C_ACT = 4'b0011, C_WR = 4'b0100, C_RD = 4'b0101, C_NOP = 4'b0111;

  logic clk = 1'b0, rst_n = 1'b0;
  logic req_valid = 1'b0, req_write = 1'b0, req_autopre = 1'b0, req_ready;
  logic [21:0] req_addr = '0;
  logic [15:0] req_wdata = '0;
  logic sd_cs_n, sd_ras_n, sd_cas_n, sd_we_n, sd_dq_oe;
  logic [1:0] sd_ba;
  logic [11:0] sd_addr;
  logic [15:0] sd_dq_out;

  always #10 clk = ~clk;

  sdram_cmd_ctrl #(
    .T_RCD(T_RCD), .T_RP(T_RP), .T_RAS(T_RAS), .T_RC(T_RC), .T_RRD(T_RRD),
    .T_WR(T_WR), .T_MRD(T_MRD), .T_RFC(T_RFC), .INIT_CYC(INIT_CYC),
    .REFI_CYC(REFI_CYC), .MODE_WORD(MODE)
  ) u_dut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_write(req_write), .req_autopre(req_autopre), .req_addr(req_addr),
    .req_wdata(req_wdata), .sd_cs_n(sd_cs_n), .sd_ras_n(sd_ras_n),
    .sd_cas_n(sd_cas_n), .sd_we_n(sd_we_n), .sd_ba(sd_ba), .sd_addr(sd_addr),
    .sd_dq_out(sd_dq_out), .sd_dq_oe(sd_dq_oe)
  );

  typedef struct {
    logic [3:0]  cmd;
    logic [1:0]  ba;
    logic [11:0] addr;
    logic [15:0] data;
  } exp_t;

  exp_t q[$];
  int n_chk = 0, n_bad = 0;
  int cyc = 0, rel_cyc = 0, acc_cyc = -100;
  int last_cmd_cyc = -100000, last_act_any = -100000, last_ref = -100000;
  logic [3:0] last_cmd = C_NOP;
  logic [3:0] open_b = '0;
  bit seen_first = 0;
  int last_act [4], last_wr [4], close_cyc [4], close_need [4];
  bit close_ap [4];

  always @(posedge clk) cyc <= cyc + 1;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: actual=%0d expected=%0d (cycle %0d)", req, act, exp, cyc);
    end
  endtask

  task automatic push(input logic [3:0] c, input logic [1:0] b, input logic [11:0] a,
                      input logic [15:0] d);
    exp_t e;
    e.cmd = c; e.ba = b; e.addr = a; e.data = d;
    q.push_back(e);
  endtask

  task automatic drain();
    while (q.size() != 0) @(negedge clk);
    repeat (2) @(negedge clk);
  endtask

  // Driver: host request, held until accepted.
  task automatic send(input logic [1:0] b, input logic [11:0] r, input logic [7:0] c,
                      input logic w, input logic ap, input logic [15:0] d);
    @(negedge clk);
    req_valid = 1'b1; req_write = w; req_autopre = ap;
    req_addr = {b, r, c}; req_wdata = d;
    #1;
    while (!req_ready) begin @(negedge clk); #1; end
    acc_cyc = cyc;
    @(negedge clk);
    req_valid = 1'b0;
  endtask

  // Monitor: pops the scoreboard and checks spacing from an independent shadow.
  always @(negedge clk) begin
    logic [3:0] c;
    c = {sd_cs_n, sd_ras_n, sd_cas_n, sd_we_n};
    if (rst_n && c != C_NOP) begin
      if (!seen_first) begin
        seen_first = 1;
        chk(cyc - rel_cyc >= INIT_CYC, "R2 power-up wait", cyc - rel_cyc, INIT_CYC);
      end
      chk(sd_dq_oe == (c == C_WR), "R5 data enable", sd_dq_oe, c == C_WR);
      if (last_cmd == C_MRS) chk(cyc - last_cmd_cyc >= T_MRD, "R3", cyc - last_cmd_cyc, T_MRD);
      if (last_cmd == C_REF) chk(cyc - last_cmd_cyc >= T_RFC, "R11 recovery", cyc - last_cmd_cyc, T_RFC);
      if (q.size() == 0) begin
        chk(0, "R1 unexpected command", c, C_NOP);
      end else begin
        exp_t e;
        e = q.pop_front();
        chk(c == e.cmd, "R1 command", c, e.cmd);
        case (e.cmd)
          C_ACT: begin
            chk(sd_ba == e.ba, "R5 act bank", sd_ba, e.ba);
            chk(sd_addr == e.addr, "R5 act row", sd_addr, e.addr);
          end
          C_RD, C_WR: begin
            chk(sd_ba == e.ba, "R5 rw bank", sd_ba, e.ba);
            chk(sd_addr[7:0] == e.addr[7:0], "R5 column", sd_addr[7:0], e.addr[7:0]);
            chk(sd_addr[10] == e.addr[10], "R9 auto-close flag", sd_addr[10], e.addr[10]);
            if (e.cmd == C_WR) chk(sd_dq_out == e.data, "R5 write data", sd_dq_out, e.data);
          end
          C_PRE: begin
            chk(sd_addr[10] == e.addr[10], "R10 all-bank flag", sd_addr[10], e.addr[10]);
            if (!e.addr[10]) chk(sd_ba == e.ba, "R8 precharge bank", sd_ba, e.ba);
          end
          C_MRS: chk(sd_addr == e.addr, "R2 mode word", sd_addr, e.addr);
          default: ;
        endcase
      end
      case (c)
        C_MRS, C_REF: chk(open_b == 0, "R4 banks closed", open_b, 0);
        C_ACT: begin
          chk(!open_b[sd_ba], "R8 act on closed bank", open_b[sd_ba], 0);
          chk(cyc - last_act_any >= T_RRD, "R6 act-act any bank", cyc - last_act_any, T_RRD);
          chk(cyc - last_act[sd_ba] >= T_RC, "R6 row cycle", cyc - last_act[sd_ba], T_RC);
          if (close_ap[sd_ba])
            chk(cyc - close_cyc[sd_ba] >= close_need[sd_ba], "R9 reopen",
                cyc - close_cyc[sd_ba], close_need[sd_ba]);
          else
            chk(cyc - close_cyc[sd_ba] >= close_need[sd_ba], "R7 precharge time",
                cyc - close_cyc[sd_ba], close_need[sd_ba]);
        end
        C_RD, C_WR: begin
          chk(open_b[sd_ba], "R5 rw on open bank", open_b[sd_ba], 1);
          chk(cyc - last_act[sd_ba] >= T_RCD, "R6 act-rw", cyc - last_act[sd_ba], T_RCD);
          if (sd_addr[10])
            chk(cyc - last_act[sd_ba] >= T_RAS, "R9 active time", cyc - last_act[sd_ba], T_RAS);
          chk(cyc == acc_cyc + 1, "R12 command after ready", cyc, acc_cyc + 1);
        end
        C_PRE: begin
          for (int b = 0; b < 4; b++) begin
            if ((sd_addr[10] || sd_ba == b) && open_b[b]) begin
              chk(cyc - last_act[b] >= T_RAS, "R6 active time", cyc - last_act[b], T_RAS);
              chk(cyc - last_wr[b] >= T_WR, "R7 write recovery", cyc - last_wr[b], T_WR);
            end
          end
        end
        default: ;
      endcase
      case (c)
        C_ACT: begin open_b[sd_ba] = 1'b1; last_act[sd_ba] = cyc; last_act_any = cyc; end
        C_RD, C_WR: begin
          if (c == C_WR) last_wr[sd_ba] = cyc;
          if (sd_addr[10]) begin
            open_b[sd_ba] = 1'b0; close_cyc[sd_ba] = cyc; close_ap[sd_ba] = 1;
            close_need[sd_ba] = (c == C_WR) ? T_WR + T_RP : T_RP;
          end
        end
        C_PRE: begin
          for (int b = 0; b < 4; b++) begin
            if (sd_addr[10] || sd_ba == b) begin
              open_b[b] = 1'b0; close_cyc[b] = cyc; close_need[b] = T_RP; close_ap[b] = 0;
            end
          end
        end
        C_REF: last_ref = cyc;
        default: ;
      endcase
      last_cmd = c;
      last_cmd_cyc = cyc;
    end
  end

  task automatic summary();
    $display("test done: total=%0d bad=%0d", n_chk, n_bad);
  endtask

  initial begin
    repeat (60000) @(posedge clk);
    chk(0, "watchdog expired", 0, 1);
    summary();
    $finish;
  end

  initial begin
    int ref1;
    for (int b = 0; b < 4; b++) begin
      last_act[b] = -100000; last_wr[b] = -100000;
      close_cyc[b] = -100000; close_need[b] = 0; close_ap[b] = 0;
    end
    repeat (3) @(negedge clk);
    chk({sd_cs_n, sd_ras_n, sd_cas_n, sd_we_n} == C_NOP, "R2 reset command",
        {sd_cs_n, sd_ras_n, sd_cas_n, sd_we_n}, C_NOP);
    chk(sd_dq_oe == 1'b0, "R2 reset data enable", sd_dq_oe, 0);
    chk(req_ready == 1'b0, "R2 reset ready", req_ready, 0);

    // Power-up sequence (R2)
    push(C_PRE, 2'd0, 12'h400, 16'h0);
    push(C_REF, 2'd0, 12'h000, 16'h0);
    push(C_REF, 2'd0, 12'h000, 16'h0);
    push(C_MRS, 2'd0, MODE, 16'h0);
    rst_n = 1'b1;
    rel_cyc = cyc;
    drain();

    // Write to a closed bank: activate, then write (R5, R6)
    push(C_ACT, 2'd0, 12'd5, 16'h0);
    push(C_WR, 2'd0, 12'h003, 16'hA5A5);
    send(2'd0, 12'd5, 8'd3, 1'b1, 1'b0, 16'hA5A5);
    drain();

    // Row hit: read with no activate (R8)
    push(C_RD, 2'd0, 12'h007, 16'h0);
    send(2'd0, 12'd5, 8'd7, 1'b0, 1'b0, 16'h0);
    drain();

    // Row miss: precharge, activate, read (R8, R7)
    push(C_PRE, 2'd0, 12'h000, 16'h0);
    push(C_ACT, 2'd0, 12'd9, 16'h0);
    push(C_RD, 2'd0, 12'h001, 16'h0);
    send(2'd0, 12'd9, 8'd1, 1'b0, 1'b0, 16'h0);
    drain();

    // Auto-closing write, then reopen the same row (R9)
    push(C_ACT, 2'd2, 12'd1, 16'h0);
    push(C_WR, 2'd2, 12'h404, 16'h1234);
    send(2'd2, 12'd1, 8'd4, 1'b1, 1'b1, 16'h1234);
    push(C_ACT, 2'd2, 12'd1, 16'h0);
    push(C_RD, 2'd2, 12'h005, 16'h0);
    send(2'd2, 12'd1, 8'd5, 1'b0, 1'b0, 16'h0);
    drain();

    // Two more banks back to back: activate spacing (R6)
    push(C_ACT, 2'd1, 12'd3, 16'h0);
    push(C_RD, 2'd1, 12'h000, 16'h0);
    send(2'd1, 12'd3, 8'd0, 1'b0, 1'b0, 16'h0);
    push(C_ACT, 2'd3, 12'd7, 16'h0);
    push(C_RD, 2'd3, 12'h002, 16'h0);
    send(2'd3, 12'd7, 8'd2, 1'b0, 1'b0, 16'h0);
    drain();

    // Refresh with open banks: precharge-all then refresh (R11, R10)
    push(C_PRE, 2'd0, 12'h400, 16'h0);
    push(C_REF, 2'd0, 12'h000, 16'h0);
    drain();
    ref1 = last_ref;

    // Refresh with all banks closed: no precharge (R11)
    push(C_REF, 2'd0, 12'h000, 16'h0);
    drain();
    chk(last_ref - ref1 >= REFI_CYC - 20 && last_ref - ref1 <= REFI_CYC + 20,
        "R11 refresh interval", last_ref - ref1, REFI_CYC);

    // Former open row of bank 0 now closed by the all-bank precharge (R10)
    push(C_ACT, 2'd0, 12'd9, 16'h0);
    push(C_RD, 2'd0, 12'h001, 16'h0);
    send(2'd0, 12'd9, 8'd1, 1'b0, 1'b0, 16'h0);
    drain();

    chk(q.size() == 0, "R1 all expected commands seen", q.size(), 0);
    summary();
    $finish;
  end
endmodule